// File: doc/BRIEF.md
# One-Bit Branch Outcome Predictor

This block guesses the direction of conditional branches for a pipelined core. It keeps one bit per table entry, recording the direction the branch mapped there went the last time it resolved. The fetch stage presents its program counter and gets a taken or not-taken guess back in the same cycle, read straight from the addressed entry. When a branch resolves in execute, the block compares the real direction with the bit it holds for that branch's address.

When the guess was right, nothing changes and the pipeline loses no cycles. When it was wrong, the block raises a mispredict flag and a two-lane squash vector in that same cycle, and it inverts the stored bit at the next clock edge. The pipeline uses these outputs to kill the two younger instructions already fetched down the wrong path and to redirect fetch. Each entry is selected by the word-address bits just above the byte offset. Branches whose addresses agree in those bits share an entry.

Top module: `bp_onebit_table`

## Requirements
- R1: After reset every entry holds not taken, so `fetch_pred_taken` is 0 for every fetch address until a resolution changes an entry.
- R2: `fetch_pred_taken` is a combinational read of the entry selected by `fetch_pc[7:2]` (64 entries, word-aligned 32-bit instructions).
- R3: `mispredict` is high in a cycle exactly when `res_valid` is 1 and `res_taken` differs from the entry selected by `res_pc[7:2]`. The flag is combinational and lasts for that cycle only.
- R4: On a mispredict the selected entry is inverted at the following rising clock edge, so the next fetch of that entry predicts the direction just resolved.
- R5: A resolution whose direction matches the stored bit leaves the entry unchanged and keeps `mispredict` low.
- R6: While `res_valid` is 0, `res_pc` and `res_taken` have no effect: no entry changes and `mispredict` stays 0.
- R7: Addresses that differ only in bits [1:0] or in bits above bit 7 select the same entry.
- R8: `squash_slots` is 2'b11 (both younger pipeline slots killed) in a mispredict cycle and 2'b00 in every other cycle.
- R9: When fetch and resolve select the same entry in the same cycle, the fetch prediction returns the value held before that cycle's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | 32 | Address of the instruction being fetched |
| fetch_pred_taken | output | 1 | Predicted direction for the fetch address (1 = taken) |
| res_valid | input | 1 | A branch resolves this cycle |
| res_pc | input | 32 | Address of the resolving branch |
| res_taken | input | 1 | Actual direction of the resolving branch (1 = taken) |
| mispredict | output | 1 | The stored guess for the resolving branch was wrong |
| squash_slots | output | 2 | Per-slot kill request for the two younger instructions |

## Verification
The assertions check on every cycle that a mispredict only appears with a valid resolution, that the squash lanes move together with the mispredict flag, that an entry holds the resolved direction one cycle after any valid resolution, and that an entry seen by fetch does not change across an idle cycle. What the assertions cannot show is the state left by long histories. The bench's scenarios cover the all-not-taken reset image, a pattern written across the whole table and read back, aliasing between distant addresses, and the read-before-update result when fetch and resolve hit one entry in the same cycle.

// File: rtl/bp_onebit_pkg.sv
package bp_onebit_pkg;
    typedef enum logic {
        OUTC_NOT_TAKEN = 1'b0,
        OUTC_TAKEN     = 1'b1
    } outcome_e;

    // Younger instructions fetched behind a branch before it resolves in execute.
    localparam int SQUASH_SLOTS = 2;
endpackage

// File: rtl/bp_pc_index.sv
module bp_pc_index #(
    parameter int PC_W    = 32,
    parameter int IDX_LSB = 2,
    parameter int IDX_W   = 6
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx
);
    logic unused_pc_bits;

    assign idx            = pc[IDX_LSB +: IDX_W];
    assign unused_pc_bits = ^{pc[PC_W-1:IDX_LSB+IDX_W], pc[IDX_LSB-1:0]};
endmodule

// File: rtl/bp_hist_array.sv
module bp_hist_array
    import bp_onebit_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [IDX_W-1:0] cmp_idx,
    input  logic             flip,
    output logic             rd_bit,
    output logic             cmp_bit
);
    typedef struct packed {
        logic [ENTRIES-1:0] hist;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (flip) begin
            tbl_d.hist[cmp_idx] = ~tbl_q.hist[cmp_idx];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbl_q.hist <= {ENTRIES{1'(OUTC_NOT_TAKEN)}};
        end else begin
            tbl_q <= tbl_d;
        end
    end

    // Both reads see the registered image, so a same-cycle flip is not visible to fetch.
    assign rd_bit  = tbl_q.hist[rd_idx];
    assign cmp_bit = tbl_q.hist[cmp_idx];
endmodule

// File: rtl/bp_resolve_check.sv
module bp_resolve_check #(
    parameter int SLOTS = 2
) (
    input  logic             res_valid,
    input  logic             res_taken,
    input  logic             stored_bit,
    output logic             miss,
    output logic [SLOTS-1:0] squash
);
    assign miss = res_valid && (res_taken != stored_bit);

    for (genvar s = 0; s < SLOTS; s++) begin : g_lane
        assign squash[s] = miss;
    end
endmodule

// File: rtl/bp_onebit_table.sv
module bp_onebit_table
    import bp_onebit_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int ENTRIES = 64,
    parameter int IDX_LSB = 2,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [PC_W-1:0]         fetch_pc,
    output logic                    fetch_pred_taken,
    input  logic                    res_valid,
    input  logic [PC_W-1:0]         res_pc,
    input  logic                    res_taken,
    output logic                    mispredict,
    output logic [SQUASH_SLOTS-1:0] squash_slots
);
    logic [IDX_W-1:0] fetch_idx;
    logic [IDX_W-1:0] res_idx;
    logic             res_stored;
    logic             miss;

    bp_pc_index #(.PC_W(PC_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W)) u_fidx (
        .pc  (fetch_pc),
        .idx (fetch_idx)
    );

    bp_pc_index #(.PC_W(PC_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W)) u_ridx (
        .pc  (res_pc),
        .idx (res_idx)
    );

    bp_hist_array #(.ENTRIES(ENTRIES)) u_tbl (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (fetch_idx),
        .cmp_idx (res_idx),
        .flip    (miss),
        .rd_bit  (fetch_pred_taken),
        .cmp_bit (res_stored)
    );

    bp_resolve_check #(.SLOTS(SQUASH_SLOTS)) u_cmp (
        .res_valid  (res_valid),
        .res_taken  (res_taken),
        .stored_bit (res_stored),
        .miss       (miss),
        .squash     (squash_slots)
    );

    assign mispredict = miss;
endmodule

// File: rtl/bp_onebit_table_chk.sv
module bp_onebit_table_chk #(
    parameter int PC_W    = 32,
    parameter int ENTRIES = 64,
    parameter int IDX_LSB = 2,
    parameter int SLOTS   = 2,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PC_W-1:0]  fetch_pc,
    input logic             fetch_pred_taken,
    input logic             res_valid,
    input logic [PC_W-1:0]  res_pc,
    input logic             res_taken,
    input logic             mispredict,
    input logic [SLOTS-1:0] squash_slots
);
    logic [IDX_W-1:0] f_idx;
    logic [IDX_W-1:0] r_idx;
    logic             unused_chk_bits;

    assign f_idx = fetch_pc[IDX_LSB +: IDX_W];
    assign r_idx = res_pc[IDX_LSB +: IDX_W];
    assign unused_chk_bits = ^{fetch_pc[PC_W-1:IDX_LSB+IDX_W], fetch_pc[IDX_LSB-1:0],
                               res_pc[PC_W-1:IDX_LSB+IDX_W], res_pc[IDX_LSB-1:0]};

    // R3: a mispredict needs a valid resolution
    a_r3_miss_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        mispredict |-> res_valid);

    // R8: both squash lanes fire with a mispredict
    a_r8_squash_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        mispredict |-> (squash_slots == {SLOTS{1'b1}}));

    // R8: no squash lane without a mispredict
    a_r8_squash_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !mispredict |-> (squash_slots == '0));

    // R4/R5: one cycle after a valid resolution its entry holds the resolved direction
    a_r4_entry_follows_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(res_valid) && (f_idx == $past(r_idx)))
            |-> (fetch_pred_taken == $past(res_taken)));

    // R6: with no resolution, an entry seen twice in a row is unchanged
    a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(res_valid) && (f_idx == $past(f_idx)))
            |-> (fetch_pred_taken == $past(fetch_pred_taken)));
endmodule

bind bp_onebit_table bp_onebit_table_chk #(
    .PC_W(PC_W), .ENTRIES(ENTRIES), .IDX_LSB(IDX_LSB), .SLOTS(bp_onebit_pkg::SQUASH_SLOTS)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .fetch_pc         (fetch_pc),
    .fetch_pred_taken (fetch_pred_taken),
    .res_valid        (res_valid),
    .res_pc           (res_pc),
    .res_taken        (res_taken),
    .mispredict       (mispredict),
    .squash_slots     (squash_slots)
);

// File: tb/sim_bp_onebit_table.sv
module sim_bp_onebit_table;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        fetch_pred_taken;
    logic        res_valid = 1'b0;
    logic [31:0] res_pc = '0;
    logic        res_taken = 1'b0;
    logic        mispredict;
    logic [1:0]  squash_slots;

    int n_checks = 0;
    int n_fail   = 0;
    logic model [64];

    always #10 clk = ~clk;

    bp_onebit_table u0 (
        .clk              (clk),
        .rst_n            (rst_n),
        .fetch_pc         (fetch_pc),
        .fetch_pred_taken (fetch_pred_taken),
        .res_valid        (res_valid),
        .res_pc           (res_pc),
        .res_taken        (res_taken),
        .mispredict       (mispredict),
        .squash_slots     (squash_slots)
    );

    function automatic int ix(input logic [31:0] pc);
        return int'(pc[7:2]);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Apply inputs after a falling edge; outputs settle before the next rising edge.
    task automatic drive(input logic [31:0] fpc, input logic rv, input logic [31:0] rpc, input logic rt);
        @(negedge clk);
        fetch_pc  = fpc;
        res_valid = rv;
        res_pc    = rpc;
        res_taken = rt;
        #2;
    endtask

    // Check the resolve-side outputs against the model, then clock and update the model.
    task automatic resolve(input string req, input logic [31:0] rpc, input logic rt, input logic rv);
        logic exp_miss;
        drive(fetch_pc, rv, rpc, rt);
        exp_miss = rv && (model[ix(rpc)] != rt);
        check(req, 32'(mispredict), 32'(exp_miss));
        check({req, "/R8"}, 32'(squash_slots), exp_miss ? 32'h3 : 32'h0);
        @(posedge clk);
        if (exp_miss) model[ix(rpc)] = rt;
    endtask

    task automatic fetch_chk(input string req, input logic [31:0] fpc);
        drive(fpc, 1'b0, res_pc, res_taken);
        check(req, 32'(fetch_pred_taken), 32'(model[ix(fpc)]));
        check({req, "/R6"}, 32'(mispredict), 32'h0);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 64; i++) model[i] = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 64; i++) begin
            drive(32'(i) << 2, 1'b0, '0, 1'b0);
            check("R1 reset not taken", 32'(fetch_pred_taken), 32'h0);
        end
        check("R8 idle squash", 32'(squash_slots), 32'h0);
    endtask

    task automatic t_first_miss();
        resolve("R3 first taken misses", 32'h0000_0100, 1'b1, 1'b1);
        fetch_chk("R4 flipped to taken", 32'h0000_0100);
    endtask

    task automatic t_correct();
        resolve("R5 matching outcome no miss", 32'h0000_0100, 1'b1, 1'b1);
        fetch_chk("R5 entry kept", 32'h0000_0100);
        resolve("R4 flip back miss", 32'h0000_0100, 1'b0, 1'b1);
        fetch_chk("R4 flipped to not taken", 32'h0000_0100);
    endtask

    task automatic t_invalid();
        resolve("R6 invalid resolve no miss", 32'h0000_0104, 1'b1, 1'b0);
        fetch_chk("R6 entry untouched", 32'h0000_0104);
    endtask

    task automatic t_alias();
        resolve("R3 alias setup miss", 32'hABC0_0010, 1'b1, 1'b1);
        drive(32'h0000_0013, 1'b0, '0, 1'b0);
        check("R7 alias low bits", 32'(fetch_pred_taken), 32'h1);
        drive(32'h7F00_0010, 1'b0, '0, 1'b0);
        check("R7 alias high bits", 32'(fetch_pred_taken), 32'h1);
        drive(32'h0000_0014, 1'b0, '0, 1'b0);
        check("R7 neighbour entry separate", 32'(fetch_pred_taken), 32'h0);
    endtask

    task automatic t_same_cycle();
        drive(32'h0000_0040, 1'b1, 32'h0000_0040, 1'b1);
        check("R9 fetch sees old value", 32'(fetch_pred_taken), 32'h0);
        check("R9 miss in same cycle", 32'(mispredict), 32'h1);
        @(posedge clk);
        model[16] = 1'b1;
        drive(32'h0000_0040, 1'b0, '0, 1'b0);
        check("R9 new value next cycle", 32'(fetch_pred_taken), 32'h1);
    endtask

    task automatic t_walk();
        for (int i = 0; i < 64; i++) begin
            resolve("R3 pattern write", 32'(i) << 2, 1'((i % 3) == 0), 1'b1);
        end
        for (int i = 0; i < 64; i++) begin
            drive(32'h1000_0000 | (32'(i) << 2), 1'b0, '0, 1'b0);
            check("R2 pattern readback", 32'(fetch_pred_taken), 32'((i % 3) == 0));
        end
    endtask

    initial begin
        t_reset();
        t_first_miss();
        t_correct();
        t_invalid();
        t_alias();
        t_same_cycle();
        t_walk();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule